// File: doc/BRIEF.md
# Toggling Binary-Tree DMA Arbiter

The block decides which of eight DMA requesters owns the bus. Requester 7 is an urgent, low-bandwidth client. It wins whenever it asks and never waits behind the others. Requesters 0 to 6 share what remains through a tree of six two-input selectors. Each selector holds a single state bit that says which of its inputs it currently favours.

The grant is combinational. It is formed from the present request vector and the registered selector bits, so a requester sees its grant in the same cycle it raises its request. The bus side pulses the acknowledge input when a grant is taken. On that edge, every selector on the path from the root down to the winning leaf turns to favour the branch that lost.

The tree is deliberately lopsided. The root splits a four-leaf branch (requesters 0 to 3) from a branch in which requester 6 is paired against a selector over 4 and 5. As a result, requester 6 gets twice the share of each other fair requester.

Top module: `dma_tree_arb`

## Requirements
- R1: After the active-low asynchronous reset, every selector favours its lower input, so with requests 0 to 6 all asserted and request 7 low the grant is requester 0 (`gnt_o == 8'h01`).
- R2: Whenever `req_i[7]` is high, `gnt_o == 8'h80`, regardless of the other requests and of selector state.
- R3: `gnt_o` is one-hot or zero, and it is zero exactly when `req_i` is zero.
- R4: A selector whose favoured side has no active request passes the other side through. Any single asserted fair request, or any non-empty fair pattern with request 7 low, yields a grant to one of the asserted requesters.
- R5: Selector state changes only on a rising clock edge with `ack_i` high while a requester among 0 to 6 is granted. An acknowledge of a requester-7 grant, an acknowledge with no grant, or a cycle without acknowledge leaves the next grant for an unchanged request vector unchanged.
- R6: On an acknowledged fair grant, each selector on the winning path favours its input that did not win. The tree is fixed: the root chooses between {0..3} and {4,5,6}; {0..3} splits into {0,1} and {2,3}; {4,5,6} splits into the {4,5} selector (lower input) and leaf 6 (upper input).
- R7: With requests 0 to 6 held high, request 7 low and every cycle acknowledged, any 8 consecutive grants give requester 6 two grants and each of requesters 0 to 5 exactly one.
- R8: The grant follows a change of `req_i` in the same cycle, with no register between request and grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request vector; bit 7 is the absolute-priority requester |
| ack_i | input | 1 | Grant acknowledge; advances selector state |
| gnt_o | output | 8 | One-hot grant, zero when idle |

## Verification
The bench checks a grant to requester 7 under acknowledge followed by a fair grant. A design that flipped selectors on that acknowledge would give the fair grant to the wrong requester. Idle acknowledges and unacknowledged cycles are checked for the same reason. Sparse request patterns whose favoured side is empty catch a tree that withholds a grant or grants an idle leaf. An eight-cycle saturation window counts grants per requester, which exposes a misplaced leaf or a selector that toggles the wrong way, and a long randomized run compares every grant against an independent tree model.

// File: rtl/dma_tree_arb_pkg.sv
package dma_tree_arb_pkg;

  localparam int unsigned N_REQ  = 8;
  localparam int unsigned FAIR_N = N_REQ - 1;
  localparam int unsigned NODES  = FAIR_N - 1;
  localparam int unsigned CODE_W = 4;

  typedef logic [FAIR_N-1:0]             leaf_vec_t;
  typedef logic [NODES-1:0][FAIR_N-1:0]  node_leaf_t;
  typedef logic [NODES-1:0][CODE_W-1:0]  child_tab_t;

  // child code: bit 3 set -> selector index, clear -> leaf index
  // node 0 root, 1 = {0..3}, 2 = {4,5,6}, 3 = {0,1}, 4 = {2,3}, 5 = {4,5}
  localparam child_tab_t CHILD_LO = {4'h4, 4'h2, 4'h0, 4'hD, 4'hB, 4'h9};
  localparam child_tab_t CHILD_HI = {4'h5, 4'h3, 4'h1, 4'h6, 4'hC, 4'hA};

  function automatic leaf_vec_t code_leaves(logic [CODE_W-1:0] code, node_leaf_t part);
    leaf_vec_t v;
    if (code[3]) v = part[code[2:0]];
    else         v = leaf_vec_t'(1) << code[2:0];
    return v;
  endfunction

  // children carry higher indices than parents, so a reverse sweep suffices
  function automatic node_leaf_t calc_subtree();
    node_leaf_t r;
    r = '0;
    for (int n = NODES - 1; n >= 0; n--) begin
      r[n] = code_leaves(CHILD_LO[n], r) | code_leaves(CHILD_HI[n], r);
    end
    return r;
  endfunction

  function automatic node_leaf_t calc_side(child_tab_t tab);
    node_leaf_t full;
    node_leaf_t r;
    full = calc_subtree();
    for (int n = 0; n < NODES; n++) r[n] = code_leaves(tab[n], full);
    return r;
  endfunction

  localparam node_leaf_t SUBTREE = calc_subtree();
  localparam node_leaf_t SIDE_LO = calc_side(CHILD_LO);
  localparam node_leaf_t SIDE_HI = calc_side(CHILD_HI);

endpackage

// File: rtl/dma_tsel_node.sv
module dma_tsel_node (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_any_i,
  input  logic hi_any_i,
  input  logic flip_i,
  output logic pick_hi_o
);

  logic fav_hi_q;

  assign pick_hi_o = fav_hi_q ? hi_any_i : (hi_any_i & ~lo_any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fav_hi_q <= 1'b0;
    else if (flip_i) fav_hi_q <= ~pick_hi_o;
  end

endmodule

// File: rtl/dma_tsel_tree.sv
module dma_tsel_tree
  import dma_tree_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FAIR_N-1:0] req_i,
  input  logic              en_i,
  input  logic              ack_i,
  output logic [FAIR_N-1:0] gnt_o
);

  logic [NODES-1:0] lo_any, hi_any, pick_hi, on_path;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    assign lo_any[n]  = |(req_i & SIDE_LO[n]);
    assign hi_any[n]  = |(req_i & SIDE_HI[n]);
    assign on_path[n] = |(gnt_o & SUBTREE[n]);

    dma_tsel_node i_node (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lo_any_i (lo_any[n]),
      .hi_any_i (hi_any[n]),
      .flip_i   (ack_i & on_path[n]),
      .pick_hi_o(pick_hi[n])
    );
  end

  // flat grant: leaf wins if every ancestor steers toward it
  for (genvar l = 0; l < FAIR_N; l++) begin : g_leaf
    logic [NODES-1:0] steer_ok;
    for (genvar n = 0; n < NODES; n++) begin : g_anc
      if (SIDE_LO[n][l]) begin : g_lo
        assign steer_ok[n] = ~pick_hi[n];
      end else if (SIDE_HI[n][l]) begin : g_hi
        assign steer_ok[n] = pick_hi[n];
      end else begin : g_none
        assign steer_ok[n] = 1'b1;
      end
    end
    assign gnt_o[l] = en_i & req_i[l] & (&steer_ok);
  end

endmodule

// File: rtl/dma_tree_arb.sv
module dma_tree_arb
  import dma_tree_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             ack_i,
  output logic [N_REQ-1:0] gnt_o
);

  localparam int unsigned URGENT = N_REQ - 1;

  logic              urgent_req;
  logic [FAIR_N-1:0] fair_gnt;

  assign urgent_req = req_i[URGENT];

  dma_tsel_tree i_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i[FAIR_N-1:0]),
    .en_i  (~urgent_req),
    .ack_i (ack_i),
    .gnt_o (fair_gnt)
  );

  assign gnt_o = {urgent_req, fair_gnt};

endmodule

// File: rtl/dma_tree_arb_chk.sv
module dma_tree_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] req_i,
  input logic       ack_i,
  input logic [7:0] gnt_o
);

  p_urgent_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[7] |-> (gnt_o == 8'h80));

  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_idle_iff_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i == 8'h00) == (gnt_o == 8'h00)));

  p_grant_requested_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == 8'h00));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i || gnt_o == 8'h00 || gnt_o[7]) |=> (!$stable(req_i) || $stable(gnt_o)));

  p_rotate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_i == 8'h7F) |=> (!$stable(req_i) || gnt_o != $past(gnt_o)));

endmodule

bind dma_tree_arb dma_tree_arb_chk i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .ack_i (ack_i),
  .gnt_o (gnt_o)
);

// File: tb/test_dma_tree_arb.sv
module test_dma_tree_arb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = 8'h00;
  logic       ack = 1'b0;
  logic [7:0] gnt;

  always #5 clk = ~clk;

  dma_tree_arb i_dma_tree_arb (
    .clk_i (clk),
    .rst_ni(rst_n),
    .req_i (req),
    .ack_i (ack),
    .gnt_o (gnt)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    obs_cnt[8];
  bit    done = 1'b0;

  // reference tree: codes < 8 are leaves, 8+n is selector n
  int ca[6] = '{9, 11, 13, 0, 2, 4};
  int cb[6] = '{10, 12, 6, 1, 3, 5};
  bit ms[6];
  int w[6];

  function automatic int side_win(int code, logic [6:0] r);
    if (code < 8) return r[code] ? code : -1;
    return w[code-8];
  endfunction

  function automatic int model_win(logic [6:0] r);
    for (int n = 5; n >= 0; n--) begin
      int wa, wb;
      wa = side_win(ca[n], r);
      wb = side_win(cb[n], r);
      if (wa < 0)      w[n] = wb;
      else if (wb < 0) w[n] = wa;
      else             w[n] = ms[n] ? wb : wa;
    end
    return w[0];
  endfunction

  function automatic void model_flip(int leaf, logic [6:0] r);
    int code;
    code = 8;
    while (code >= 8) begin
      int n;
      n = code - 8;
      if (side_win(ca[n], r) == leaf) begin
        ms[n] = 1'b1;
        code  = ca[n];
      end else begin
        ms[n] = 1'b0;
        code  = cb[n];
      end
    end
  endfunction

  task automatic step(input logic [7:0] r, input logic a, input string tag);
    item_t it;
    int    wn;
    @(negedge clk);
    req = r;
    ack = a;
    wn  = model_win(r[6:0]);
    if (r[7])        it.exp = 8'h80;
    else if (wn < 0) it.exp = 8'h00;
    else             it.exp = 8'h01 << wn;
    it.tag = tag;
    q.push_back(it);
    if (a && rst_n && !r[7] && wn >= 0) model_flip(wn, r[6:0]);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (gnt !== it.exp) begin
          n_fail++;
          $display("FAIL %s: gnt=%h expected=%h", it.tag, gnt, it.exp);
        end
        for (int i = 0; i < 8; i++) obs_cnt[i] += int'(gnt[i]);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 6; i++) ms[i] = 1'b0;
    step(8'h00, 1'b0, "R3 reset idle");
    @(negedge clk);
    rst_n = 1'b1;

    step(8'h7F, 1'b0, "R1 reset favours lowest");
    step(8'h7F, 1'b0, "R5 no ack holds");
    step(8'hFF, 1'b1, "R2 urgent wins");
    step(8'h81, 1'b1, "R2 urgent wins sparse");
    step(8'h7F, 1'b0, "R5 urgent ack leaves tree");
    step(8'h00, 1'b1, "R3 idle no grant");
    step(8'h7F, 1'b0, "R5 idle ack leaves tree");
    step(8'h7F, 1'b1, "R6 ack flips path");
    step(8'h7F, 1'b0, "R6 opposite branch next");
    step(8'h03, 1'b0, "R8 grant follows request");

    drain();
    for (int i = 0; i < 8; i++) obs_cnt[i] = 0;
    for (int k = 0; k < 8; k++) step(8'h7F, 1'b1, "R7 saturation");
    drain();
    for (int i = 0; i < 7; i++) begin
      int e;
      e = (i == 6) ? 2 : 1;
      n_chk++;
      if (obs_cnt[i] != e) begin
        n_fail++;
        $display("FAIL R7 share of %0d: count=%0d expected=%0d", i, obs_cnt[i], e);
      end
    end

    for (int l = 0; l < 7; l++) step(8'h01 << l, 1'b1, "R4 single request");
    step(8'h0C, 1'b1, "R4 empty favoured side");
    step(8'h30, 1'b1, "R4 pair under deep node");
    step(8'h40, 1'b0, "R4 leaf six alone");

    for (int k = 0; k < 600; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if ($urandom_range(7, 0) != 0) r[7] = 1'b0;
      if ($urandom_range(5, 0) == 0) r = 8'h00;
      step(r, 1'($urandom), "R6 random vs model");
    end

    drain();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule